// File: doc/BRIEF.md
# Decimating FIR Multiply-Accumulate Cell

This block is a single tap cell meant to be chained into a longer FIR filter. Every clock it multiplies the coefficient held in its input coefficient register by the data sample held in its data register. It adds that product into a 26-bit running sum. The coefficient also travels onward through a short delay line of up to three extra stages, and a cascade output hands it to the next cell in the chain. The number of extra stages sets the rate at which coefficients step from cell to cell, and that rate gives output decimation by 2, 3 or 4.

Each operand is read as either unsigned or two's complement, chosen separately for the coefficient and for the data. Both a delayed synchronous reset and a separate sum-clear input are provided. The reset empties the coefficient stages, the data register and the mode register but leaves the running sum alone. The clear input is the only way to zero the sum, so software sequencing decides when each output point starts.

Top module: `fir_mac_cell`

## Requirements
- R1: On every clock edge where `acc_clear` is low, `acc_out` becomes its previous value plus the product of the stored coefficient and the stored data register, sign- or zero-extended to 26 bits.
- R2: When `acc_clear` is high at an edge, `acc_out` is 0 after that edge, and the product of that cycle is discarded. This holds also while reset is active.
- R3: With `dec_mode` = 2'b00, `coef_out` shows the coefficient loaded at an edge with `coef_load` high right after that edge.
- R4: With `dec_mode` = 2'b01, 2'b10 or 2'b11, the coefficient reaches `coef_out` 1, 2 or 3 loading edges later than in R3.
- R5: `dec_mode` is registered. A new mode changes the `coef_out` selection only after the next clock edge.
- R6: While `coef_load` is low, the coefficient register and all delay stages hold their contents, whatever `coef_in` does.
- R7: While `data_load` is low, the data register holds its value, so the product added each clock stays the same.
- R8: `coef_is_signed` = 1 makes the coefficient two's complement (0 makes it unsigned). `data_is_signed` does the same for the data, independently. With coefficient 8'hFE and data 8'h83, the product is 33274, −262, −31750 or 250 for (coef, data) signedness 00, 10, 01, 11.
- R9: `rst` is active-high and synchronous and is itself registered. It clears the coefficient stages, the data register and the mode register one clock after it is sampled. `acc_out` is not affected by it.
- R10: The sum wraps modulo 2^26 and gives no overflow indication. For example, −1 × 1 added to 0 gives 26'h3FFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, acts one cycle late |
| coef_in | input | 8 | Coefficient from the previous cell or source |
| coef_load | input | 1 | High: coefficient register and delay stages advance |
| data_in | input | 8 | Broadcast data sample |
| data_load | input | 1 | High: data register captures `data_in` |
| dec_mode | input | 2 | Number of extra delay stages on the cascade path (0–3) |
| coef_is_signed | input | 1 | Coefficient read as two's complement when high |
| data_is_signed | input | 1 | Data read as two's complement when high |
| acc_clear | input | 1 | High: sum is loaded with zero at the edge |
| coef_out | output | 8 | Coefficient cascade to the next cell |
| acc_out | output | 26 | Running 26-bit sum |

## Verification
The clear and the accumulation meet on the same edge whenever `acc_clear` is raised while a nonzero product is present. The directed collision test builds up a nonzero sum and then asserts the clear with that product still live. It expects exactly zero rather than the product. The delayed reset and the accumulation also overlap: for one edge the reset has been sampled but has not yet acted. That case is provoked with a loaded coefficient and data. The sum must take one more product from the old operands and then keep its value once the operands are cleared.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  // Cascade-path delay selection; the value is the count of extra stages.
  typedef enum logic [1:0] {
    DLY_NONE  = 2'd0,
    DLY_ONE   = 2'd1,
    DLY_TWO   = 2'd2,
    DLY_THREE = 2'd3
  } dly_mode_e;

  // Operand interpretation pair handed to the multiplier.
  typedef struct packed {
    logic coef_signed;
    logic data_signed;
  } opnd_fmt_t;

  localparam int DEF_COEF_W = 8;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ACC_W  = 26;
  localparam int DEF_DLY_N  = 3;

endpackage

// File: rtl/fir_mac_coef_pipe.sv
module fir_mac_coef_pipe #(
  parameter  int W      = 8,
  parameter  int DEPTH  = 3,
  localparam int SEL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             flush,
  input  logic             load,
  input  logic [W-1:0]     d,
  input  logic [SEL_W-1:0] tap,
  output logic [W-1:0]     head,
  output logic [W-1:0]     q
);

  // stage[0] is the coefficient register, stage[1..DEPTH] the delay line.
  logic [W-1:0] stage [0:DEPTH];

  for (genvar i = 0; i <= DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (flush)     stage[i] <= '0;
        else if (load) stage[i] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (flush)     stage[i] <= '0;
        else if (load) stage[i] <= stage[i-1];
      end
    end
  end

  assign head = stage[0];

  always_comb begin
    if (32'(tap) > DEPTH) q = stage[DEPTH];
    else                  q = stage[tap];
  end

  // R6: a frozen load keeps the whole line unchanged
  assert_line_freeze_R6: assert property (@(posedge clk) disable iff (flush)
    !load |=> ($stable(stage[0]) && $stable(stage[DEPTH])));

endmodule

// File: rtl/fir_mac_mult.sv
module fir_mac_mult
  import fir_mac_pkg::*;
#(
  parameter  int CW = 8,
  parameter  int DW = 8,
  parameter  int OW = 26,
  localparam int PW = CW + DW + 2
) (
  input  logic [CW-1:0] coef,
  input  logic [DW-1:0] data,
  input  opnd_fmt_t     fmt,
  output logic [OW-1:0] prod
);

  logic signed [CW:0]   coef_x;
  logic signed [DW:0]   data_x;
  logic signed [PW-1:0] full;

  // One extra bit per operand turns either reading into a signed value.
  assign coef_x = {fmt.coef_signed & coef[CW-1], coef};
  assign data_x = {fmt.data_signed & data[DW-1], data};
  assign full   = PW'(coef_x) * PW'(data_x);

  if (OW > PW) begin : g_ext
    assign prod = {{(OW-PW){full[PW-1]}}, full};
  end else begin : g_trim
    assign prod = full[OW-1:0];
  end

endmodule

// File: rtl/fir_mac_accum.sv
module fir_mac_accum #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] addend,
  output logic [W-1:0] sum
);

  // Deliberately no reset: only the clear input zeroes the sum.
  always_ff @(posedge clk) begin
    if (clr) sum <= '0;
    else     sum <= sum + addend;
  end

endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell
  import fir_mac_pkg::*;
#(
  parameter  int COEF_W = DEF_COEF_W,
  parameter  int DATA_W = DEF_DATA_W,
  parameter  int ACC_W  = DEF_ACC_W,
  parameter  int DLY_N  = DEF_DLY_N,
  localparam int MODE_W = $clog2(DLY_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_load,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_load,
  input  logic [MODE_W-1:0] dec_mode,
  input  logic              coef_is_signed,
  input  logic              data_is_signed,
  input  logic              acc_clear,
  output logic [COEF_W-1:0] coef_out,
  output logic [ACC_W-1:0]  acc_out
);

  logic              rst_q;
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] data_q;
  logic [COEF_W-1:0] coef_q;
  logic [ACC_W-1:0]  product;
  opnd_fmt_t         fmt;

  // Reset is registered and acts one clock after it is sampled.
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      mode_q <= '0;
      data_q <= '0;
    end else begin
      mode_q <= dec_mode;
      if (data_load) data_q <= data_in;
    end
  end

  fir_mac_coef_pipe #(
    .W     (COEF_W),
    .DEPTH (DLY_N)
  ) u_pipe (
    .clk   (clk),
    .flush (rst_q),
    .load  (coef_load),
    .d     (coef_in),
    .tap   (mode_q),
    .head  (coef_q),
    .q     (coef_out)
  );

  assign fmt.coef_signed = coef_is_signed;
  assign fmt.data_signed = data_is_signed;

  fir_mac_mult #(
    .CW (COEF_W),
    .DW (DATA_W),
    .OW (ACC_W)
  ) u_mult (
    .coef (coef_q),
    .data (data_q),
    .fmt  (fmt),
    .prod (product)
  );

  fir_mac_accum #(
    .W (ACC_W)
  ) u_acc (
    .clk    (clk),
    .clr    (acc_clear),
    .addend (product),
    .sum    (acc_out)
  );

  // R1: the sum steps by the multiplier result when not cleared
  assert_sum_step_R1: assert property (@(posedge clk) disable iff (rst)
    !acc_clear |=> (acc_out == $past(acc_out) + $past(product)));

  // R2: a clear leaves exactly zero
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
    acc_clear |=> (acc_out == '0));

  // R3: without delay stages the cascade shows the last loaded coefficient
  assert_direct_tap_R3: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && coef_load && mode_q == '0 && dec_mode == '0)
      |=> (coef_out == $past(coef_in)));

  // R5: the mode takes effect one clock after being applied
  assert_mode_lag_R5: assert property (@(posedge clk) disable iff (rst)
    !rst_q |=> (mode_q == $past(dec_mode)));

  // R7: data register holds while its load is low
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst_q && !data_load) |=> $stable(data_q));

  // R9: the delayed reset empties the cascade and data paths
  assert_late_reset_R9: assert property (@(posedge clk) disable iff (rst)
    rst_q |=> (coef_out == '0 && data_q == '0));

endmodule

// File: tb/fir_mac_cell_bench.sv
module fir_mac_cell_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  coef_in = '0;
  logic        coef_load = 1'b0;
  logic [7:0]  data_in = '0;
  logic        data_load = 1'b0;
  logic [1:0]  dec_mode = '0;
  logic        coef_is_signed = 1'b0;
  logic        data_is_signed = 1'b0;
  logic        acc_clear = 1'b1;
  logic [7:0]  coef_out;
  logic [25:0] acc_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fir_mac_cell u_fir_mac_cell (
    .clk            (clk),
    .rst            (rst),
    .coef_in        (coef_in),
    .coef_load      (coef_load),
    .data_in        (data_in),
    .data_load      (data_load),
    .dec_mode       (dec_mode),
    .coef_is_signed (coef_is_signed),
    .data_is_signed (data_is_signed),
    .acc_clear      (acc_clear),
    .coef_out       (coef_out),
    .acc_out        (acc_out)
  );

  // Requirement-level model used for the pseudo-random sweep.
  function automatic logic [25:0] ref_prod(logic [7:0] c, logic [7:0] d, logic cs, logic ds);
    int ci;
    int di;
    if (cs) ci = int'($signed(c)); else ci = int'(c);
    if (ds) di = int'($signed(d)); else di = int'(d);
    return 26'(ci * di);
  endfunction

  logic        m_rq;
  logic [7:0]  m_c, m_d1, m_d2, m_d3, m_d;
  logic [1:0]  m_mode;
  logic [25:0] m_acc;

  always @(posedge clk) begin
    m_rq <= rst;
    if (m_rq) begin
      m_c <= '0; m_d1 <= '0; m_d2 <= '0; m_d3 <= '0; m_d <= '0; m_mode <= '0;
    end else begin
      m_mode <= dec_mode;
      if (coef_load) begin
        m_c <= coef_in; m_d1 <= m_c; m_d2 <= m_d1; m_d3 <= m_d2;
      end
      if (data_load) m_d <= data_in;
    end
    m_acc <= acc_clear ? 26'd0 : m_acc + ref_prod(m_c, m_d, coef_is_signed, data_is_signed);
  end

  function automatic logic [7:0] ref_cout();
    case (m_mode)
      2'd0:    return m_c;
      2'd1:    return m_d1;
      2'd2:    return m_d2;
      default: return m_d3;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; acc_clear = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R9 cascade after reset", 32'(coef_out), 32'h0);
    chk("R2 sum cleared", 32'(acc_out), 32'h0);
    coef_in = 8'h5A; coef_load = 1'b1; data_in = 8'h01; data_load = 1'b1;
    tick();
    coef_load = 1'b0; data_load = 1'b0; acc_clear = 1'b0; rst = 1'b1;
    tick();
    chk("R9 reset not yet acting", 32'(coef_out), 32'h5A);
    chk("R1 sum during late reset", 32'(acc_out), 32'h5A);
    rst = 1'b0;
    tick();
    chk("R9 reset clears cascade", 32'(coef_out), 32'h0);
    chk("R9 sum untouched by reset", 32'(acc_out), 32'hB4);
    tick();
    chk("R9 data cleared, sum holds", 32'(acc_out), 32'hB4);
  endtask

  task automatic t_direct();
    dec_mode = 2'd0; coef_load = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      coef_in = 8'(8'h11 * i);
      tick();
      chk("R3 direct cascade", 32'(coef_out), 32'(8'h11 * i));
    end
  endtask

  task automatic t_decim();
    for (int k = 1; k <= 3; k++) begin
      dec_mode = 2'(k); coef_load = 1'b1;
      for (int i = 0; i < 8; i++) begin
        coef_in = 8'(16 * k + i);
        tick();
        if (i >= k) chk("R4 delayed cascade", 32'(coef_out), 32'(16 * k + i - k));
      end
    end
  endtask

  task automatic t_mode_lag();
    coef_load = 1'b0; dec_mode = 2'd1;
    #1;
    chk("R5 old mode before edge", 32'(coef_out), 32'h34);
    tick();
    chk("R5 new mode after edge", 32'(coef_out), 32'h36);
    dec_mode = 2'd0;
    tick();
    chk("R5 direct after edge", 32'(coef_out), 32'h37);
  endtask

  task automatic t_freeze();
    dec_mode = 2'd2; coef_load = 1'b0;
    for (int i = 0; i < 4; i++) begin
      coef_in = 8'(8'hC3 + 7 * i);
      tick();
      chk("R6 frozen line", 32'(coef_out), 32'h35);
    end
  endtask

  task automatic t_data_hold();
    coef_in = 8'd2; coef_load = 1'b1; data_in = 8'd3; data_load = 1'b1;
    coef_is_signed = 1'b0; data_is_signed = 1'b0; acc_clear = 1'b1;
    tick();
    coef_load = 1'b0; data_load = 1'b0;
    tick();
    acc_clear = 1'b0;
    for (int i = 1; i <= 3; i++) begin
      data_in = 8'(8'hF0 + i);
      tick();
      chk("R7 held data product", 32'(acc_out), 32'(6 * i));
    end
  endtask

  task automatic t_sign();
    logic [25:0] exp_tab [4];
    exp_tab[0] = 26'h00081FA;
    exp_tab[1] = 26'h3FF83FA;
    exp_tab[2] = 26'h3FFFEFA;
    exp_tab[3] = 26'h00000FA;
    coef_in = 8'hFE; data_in = 8'h83; coef_load = 1'b1; data_load = 1'b1; acc_clear = 1'b1;
    tick();
    coef_load = 1'b0; data_load = 1'b0;
    for (int s = 0; s < 4; s++) begin
      acc_clear = 1'b1;
      tick();
      acc_clear = 1'b0; coef_is_signed = s[1]; data_is_signed = s[0];
      tick();
      chk("R8 signedness product", 32'(acc_out), 32'(exp_tab[s]));
    end
  endtask

  task automatic t_wrap();
    logic [25:0] prev;
    bit          wrapped;
    longint      total;
    coef_in = 8'hFF; data_in = 8'h01; coef_load = 1'b1; data_load = 1'b1;
    coef_is_signed = 1'b1; data_is_signed = 1'b0; acc_clear = 1'b1;
    tick();
    coef_load = 1'b0; data_load = 1'b0;
    tick();
    acc_clear = 1'b0;
    tick();
    chk("R10 minus one wraps", 32'(acc_out), 32'h03FFFFFF);
    data_in = 8'hFF; data_load = 1'b1; coef_is_signed = 1'b0; acc_clear = 1'b1;
    tick();
    data_load = 1'b0;
    tick();
    acc_clear = 1'b0;
    prev = '0; wrapped = 1'b0;
    for (int i = 0; i < 1040; i++) begin
      tick();
      if (acc_out < prev) wrapped = 1'b1;
      prev = acc_out;
    end
    total = 64'd1040 * 64'd65025;
    chk("R10 wrap seen", 32'(wrapped), 32'h1);
    chk("R10 wrapped total", 32'(acc_out), 32'(total % 64'd67108864));
  endtask

  task automatic t_collide();
    coef_in = 8'd9; data_in = 8'd7; coef_load = 1'b1; data_load = 1'b1;
    coef_is_signed = 1'b0; data_is_signed = 1'b0; acc_clear = 1'b0;
    tick();
    coef_load = 1'b0; data_load = 1'b0;
    tick();
    acc_clear = 1'b1;
    tick();
    chk("R2 clear beats product", 32'(acc_out), 32'h0);
    acc_clear = 1'b0;
    tick();
    chk("R1 first product after clear", 32'(acc_out), 32'd63);
    acc_clear = 1'b1; rst = 1'b1;
    tick();
    chk("R2 clear during reset", 32'(acc_out), 32'h0);
    rst = 1'b0; acc_clear = 1'b0;
    tick();
    tick();
  endtask

  task automatic t_sweep();
    logic [15:0] lf = 16'hACE1;
    acc_clear = 1'b1;
    tick();
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      coef_in = lf[7:0]; data_in = lf[15:8];
      coef_load = lf[3]; data_load = lf[9];
      dec_mode = lf[5:4]; coef_is_signed = lf[11]; data_is_signed = lf[6];
      acc_clear = (lf[14:11] == 4'd0);
      tick();
      chk("R1 swept sum", 32'(acc_out), 32'(m_acc));
      chk("R4 swept cascade", 32'(coef_out), 32'(ref_cout()));
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    t_reset();
    t_direct();
    t_decim();
    t_mode_lag();
    t_freeze();
    t_data_hold();
    t_sign();
    t_wrap();
    t_collide();
    t_sweep();
    finish_run();
  end

endmodule